// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status store of a multichannel DMA engine. It sits on a simple device-control register bus with a 10-bit register number, 32-bit data, and separate read and write strobes. It holds these registers:

- a global configuration word;
- an error status word and an interrupt enable word;
- channel-activate set and reset words for the transmit side and for the receive side;
- end-of-buffer and descriptor-error status words for each direction.

Three windowed arrays hold per-channel state: a table pointer for each transmit channel, a table pointer for each receive channel, and a receive buffer size for each receive channel. Parameters set the transmit and receive channel counts, and the size of each window follows those counts.

The DMA datapath raises status through single-cycle set pulses on dedicated inputs. Software clears status by writing ones. A bit in the configuration word restarts the control state without disturbing the per-channel arrays. One interrupt line combines the enabled status groups.

Top module: `dmac_csr_bank`

## Requirements
- R1: After the synchronous reset, the configuration word (0x180) reads 0x0007C000. Every status, enable, activate, pointer and buffer-size register reads 0, and `irq` is 0.
- R2: A write to 0x180 stores the data ANDed with 0x00FFC087. When bit 31 of that data is 1, the error status, interrupt enable, activate and all four end-of-buffer/descriptor-error registers return to 0 in the same cycle.
- R3: The soft restart of R2 leaves every channel table pointer and buffer size unchanged.
- R4: The registers at 0x181, 0x186, 0x187, 0x192 and 0x193 are write-one-to-clear. Each 1 in the write data clears that bit, and each 0 leaves it unchanged.
- R5: A 1 on `err_set`, `tx_eob_set`, `tx_derr_set`, `rx_eob_set` or `rx_derr_set` sets the same bit of 0x181, 0x186, 0x187, 0x192 or 0x193 respectively at the next edge. If a set and a clear reach the same bit in the same cycle, the set wins.
- R6: The interrupt enable register (0x182) keeps only bits [4:0]. The transmit activate set and reset registers (0x184, 0x185) keep only bits [31:28]. The receive activate set and reset registers (0x190, 0x191) keep only bits [31:30].
- R7: Transmit table pointer i is at 0x1A0+i and receive table pointer i is at 0x1C0+i; both hold 32 bits. Receive buffer size i is at 0x1E0+i and keeps only bits [7:0]. Each window covers exactly `TXC_NUM` or `RXC_NUM` entries. A channel count outside 1..32 stops elaboration.
- R8: A register number that none of the above decodes, including one just past the end of a window, reads 0. A write to it changes nothing.
- R9: `bus_rvalid` is 1 exactly in the cycle after a cycle with `bus_rd`. In that cycle `bus_rdata` holds the value the addressed register had when the read was taken.
- R10: `irq` is a registered OR of the five enabled groups. Enable bit 0 gates the error status, bit 1 transmit end-of-buffer, bit 2 receive end-of-buffer, bit 3 transmit descriptor-error and bit 4 receive descriptor-error. A group counts when any bit of it is 1. `irq` follows a change in enable or status one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| bus_addr | input | 10 | Register number for read and write |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| err_set | input | 32 | Set pulses into the error status register |
| tx_eob_set | input | 32 | Set pulses into transmit end-of-buffer status |
| tx_derr_set | input | 32 | Set pulses into transmit descriptor-error status |
| rx_eob_set | input | 32 | Set pulses into receive end-of-buffer status |
| rx_derr_set | input | 32 | Set pulses into receive descriptor-error status |
| irq | output | 1 | Registered interrupt request |

## Verification
Every register can be read back, so a wrong stored bit shows up on `bus_rdata` on the first read of that register, one cycle after the strobe. A mask, clear or set-priority error therefore appears within two cycles of the write or pulse that caused it.

A wrong status or enable bit also reaches `irq` one cycle after the state changes, even when software never reads the register. This makes interrupt checks the fastest way to see state corrupted by a soft restart.

Window decode errors appear as aliasing. Nonzero data read from a number just past a window, or a neighbour entry overwritten, shows that the decode is wrong.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
  localparam int AW       = 10;
  localparam int DW       = 32;
  localparam int MAX_CHAN = 32;
  localparam int NSRC     = 5;

  // Register numbers decoded by software drivers; positions are fixed.
  localparam logic [AW-1:0] A_GCFG     = 10'h180;
  localparam logic [AW-1:0] A_ERRST    = 10'h181;
  localparam logic [AW-1:0] A_IRQEN    = 10'h182;
  localparam logic [AW-1:0] A_TXACT_S  = 10'h184;
  localparam logic [AW-1:0] A_TXACT_R  = 10'h185;
  localparam logic [AW-1:0] A_TXEOB    = 10'h186;
  localparam logic [AW-1:0] A_TXDERR   = 10'h187;
  localparam logic [AW-1:0] A_RXACT_S  = 10'h190;
  localparam logic [AW-1:0] A_RXACT_R  = 10'h191;
  localparam logic [AW-1:0] A_RXEOB    = 10'h192;
  localparam logic [AW-1:0] A_RXDERR   = 10'h193;
  localparam int            A_TXPTR_BASE = 'h1A0;
  localparam int            A_RXPTR_BASE = 'h1C0;
  localparam int            A_RXBSZ_BASE = 'h1E0;

  localparam logic [DW-1:0] GCFG_RST   = 32'h0007_C000;
  localparam logic [DW-1:0] GCFG_KEEP  = 32'h00FF_C087;
  localparam logic [DW-1:0] TXACT_KEEP = 32'hF000_0000;
  localparam logic [DW-1:0] RXACT_KEEP = 32'hC000_0000;
  localparam logic [DW-1:0] BSZ_KEEP   = 32'h0000_00FF;
  localparam logic [DW-1:0] PTR_KEEP   = 32'hFFFF_FFFF;
  localparam logic [NSRC-1:0] IRQEN_KEEP = 5'h1F;
  localparam int GCFG_SOFT_BIT = 31;

  // Interrupt enable bit positions
  localparam int IRQ_ERR    = 0;
  localparam int IRQ_TXEOB  = 1;
  localparam int IRQ_RXEOB  = 2;
  localparam int IRQ_TXDERR = 3;
  localparam int IRQ_RXDERR = 4;
endpackage

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  RSTV = '0,
  parameter logic [W-1:0]  KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // A write wins over the soft restart so that the restart-plus-store on the
  // configuration word ends with the stored value.
  always_ff @(posedge clk) begin
    if (rst)           q <= RSTV;
    else if (wr_hit)   q <= wdata & KEEP;
    else if (soft_clr) q <= RSTV;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (q == ($past(wdata) & KEEP))); // R6

  AST_SOFT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (soft_clr && !wr_hit) |=> (q == RSTV)); // R2
endmodule

// File: rtl/dmac_w1c_reg.sv
module dmac_w1c_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic [W-1:0] kept;

  always_comb begin
    if (soft_clr)    kept = '0;
    else if (wr_hit) kept = q & ~wdata;
    else             kept = q;
  end

  // Set pulses are ORed in after the clear so they always survive.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= kept | set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !soft_clr) |=> ((q & $past(wdata) & ~$past(set)) == '0)); // R4

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !soft_clr && (set == '0)) |=> $stable(q)); // R4
endmodule

// File: rtl/dmac_chan_window.sv
module dmac_chan_window #(
  parameter int                        N    = 4,
  parameter int                        BASE = 'h1A0,
  parameter logic [dmac_csr_pkg::DW-1:0] KEEP = '1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [dmac_csr_pkg::AW-1:0]   addr,
  input  logic [dmac_csr_pkg::DW-1:0]   wdata,
  output logic                          hit,
  output logic [dmac_csr_pkg::DW-1:0]   rdata
);
  import dmac_csr_pkg::*;

  logic [DW-1:0] ent [N];
  logic [N-1:0]  sel;

  // One-hot entry select; numbers past BASE+N-1 select nothing.
  always_comb begin
    for (int i = 0; i < N; i++) sel[i] = (addr == AW'(BASE + i));
  end

  assign hit = |sel;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) if (sel[i]) rdata = rdata | ent[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;
    end else if (wr) begin
      for (int i = 0; i < N; i++) if (sel[i]) ent[i] <= wdata & KEEP;
    end
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R7

  AST_WIN_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr && hit) |=> (rdata == ($past(wdata) & KEEP)) || ($past(addr) != addr)); // R7
endmodule

// File: rtl/dmac_irq_gen.sv
module dmac_irq_gen #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] pend,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(en & pend);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq); // R10

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ((en & pend) != '0) |=> irq); // R10
endmodule

// File: rtl/dmac_csr_bank.sv
module dmac_csr_bank #(
  parameter int TXC_NUM = 4,
  parameter int RXC_NUM = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic [31:0] err_set,
  input  logic [31:0] tx_eob_set,
  input  logic [31:0] tx_derr_set,
  input  logic [31:0] rx_eob_set,
  input  logic [31:0] rx_derr_set,
  output logic        irq
);
  import dmac_csr_pkg::*;

  // Channel counts are checked while the design is elaborated.
  if ((TXC_NUM < 1) || (TXC_NUM > MAX_CHAN)) begin : g_txc_bad
    $error("TXC_NUM must lie in 1..32"); // R7
  end
  if ((RXC_NUM < 1) || (RXC_NUM > MAX_CHAN)) begin : g_rxc_bad
    $error("RXC_NUM must lie in 1..32"); // R7
  end

  logic soft_rst;
  assign soft_rst = bus_wr && (bus_addr == A_GCFG) && bus_wdata[GCFG_SOFT_BIT];

  function automatic logic wr_at(input logic [AW-1:0] a, input logic we,
                                 input logic [AW-1:0] num);
    return we && (a == num);
  endfunction

  // ---------------- control words with write masks ----------------
  logic [DW-1:0]   gcfg_q, txact_s_q, txact_r_q, rxact_s_q, rxact_r_q;
  logic [NSRC-1:0] irqen_q;

  dmac_mask_reg #(.W(DW), .RSTV(GCFG_RST), .KEEP(GCFG_KEEP)) u_gcfg (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_GCFG)), .wdata(bus_wdata), .q(gcfg_q));

  dmac_mask_reg #(.W(NSRC), .RSTV('0), .KEEP(IRQEN_KEEP)) u_irqen (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_IRQEN)), .wdata(bus_wdata[NSRC-1:0]), .q(irqen_q));

  dmac_mask_reg #(.W(DW), .RSTV('0), .KEEP(TXACT_KEEP)) u_txact_s (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_TXACT_S)), .wdata(bus_wdata), .q(txact_s_q));

  dmac_mask_reg #(.W(DW), .RSTV('0), .KEEP(TXACT_KEEP)) u_txact_r (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_TXACT_R)), .wdata(bus_wdata), .q(txact_r_q));

  dmac_mask_reg #(.W(DW), .RSTV('0), .KEEP(RXACT_KEEP)) u_rxact_s (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_RXACT_S)), .wdata(bus_wdata), .q(rxact_s_q));

  dmac_mask_reg #(.W(DW), .RSTV('0), .KEEP(RXACT_KEEP)) u_rxact_r (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .wr_hit(wr_at(bus_addr, bus_wr, A_RXACT_R)), .wdata(bus_wdata), .q(rxact_r_q));

  // ---------------- write-one-to-clear status words ----------------
  localparam int NST = 5;
  localparam logic [AW-1:0] ST_ADDR [NST] = '{A_ERRST, A_TXEOB, A_RXEOB, A_TXDERR, A_RXDERR};

  logic [DW-1:0]   st_set [NST];
  logic [DW-1:0]   st_q   [NST];
  logic [NSRC-1:0] st_pend;

  // Order follows the interrupt enable bit positions.
  assign st_set[IRQ_ERR]    = err_set;
  assign st_set[IRQ_TXEOB]  = tx_eob_set;
  assign st_set[IRQ_RXEOB]  = rx_eob_set;
  assign st_set[IRQ_TXDERR] = tx_derr_set;
  assign st_set[IRQ_RXDERR] = rx_derr_set;

  for (genvar g = 0; g < NST; g++) begin : g_status
    dmac_w1c_reg #(.W(DW)) u_st (
      .clk(clk), .rst(rst), .soft_clr(soft_rst),
      .wr_hit(wr_at(bus_addr, bus_wr, ST_ADDR[g])),
      .wdata(bus_wdata), .set(st_set[g]), .q(st_q[g]));
    assign st_pend[g] = |st_q[g];
  end

  // ---------------- per-channel windows ----------------
  logic          txp_hit, rxp_hit, bsz_hit;
  logic [DW-1:0] txp_rd, rxp_rd, bsz_rd;

  dmac_chan_window #(.N(TXC_NUM), .BASE(A_TXPTR_BASE), .KEEP(PTR_KEEP)) u_txptr (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hit(txp_hit), .rdata(txp_rd));

  dmac_chan_window #(.N(RXC_NUM), .BASE(A_RXPTR_BASE), .KEEP(PTR_KEEP)) u_rxptr (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hit(rxp_hit), .rdata(rxp_rd));

  dmac_chan_window #(.N(RXC_NUM), .BASE(A_RXBSZ_BASE), .KEEP(BSZ_KEEP)) u_rxbsz (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hit(bsz_hit), .rdata(bsz_rd));

  // ---------------- read path ----------------
  logic [DW-1:0] rd_next;

  always_comb begin
    unique case (bus_addr)
      A_GCFG:    rd_next = gcfg_q;
      A_ERRST:   rd_next = st_q[IRQ_ERR];
      A_IRQEN:   rd_next = DW'(irqen_q);
      A_TXACT_S: rd_next = txact_s_q;
      A_TXACT_R: rd_next = txact_r_q;
      A_TXEOB:   rd_next = st_q[IRQ_TXEOB];
      A_TXDERR:  rd_next = st_q[IRQ_TXDERR];
      A_RXACT_S: rd_next = rxact_s_q;
      A_RXACT_R: rd_next = rxact_r_q;
      A_RXEOB:   rd_next = st_q[IRQ_RXEOB];
      A_RXDERR:  rd_next = st_q[IRQ_RXDERR];
      default:   rd_next = txp_rd | rxp_rd | bsz_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

  // ---------------- interrupt ----------------
  dmac_irq_gen #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .en(irqen_q), .pend(st_pend), .irq(irq));

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R9

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R9

  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    $countones({txp_hit, rxp_hit, bsz_hit}) <= 1); // R8

  AST_SOFT_DROPS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (irqen_q == '0)); // R2
endmodule

// File: tb/sim_dmac_csr_bank.sv
`timescale 1ns/1ps
module sim_dmac_csr_bank;
  localparam int TXC = 4;
  localparam int RXC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] err_set = '0, tx_eob_set = '0, tx_derr_set = '0;
  logic [31:0] rx_eob_set = '0, rx_derr_set = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dmac_csr_bank #(.TXC_NUM(TXC), .RXC_NUM(RXC)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .err_set(err_set), .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set),
    .rx_eob_set(rx_eob_set), .rx_derr_set(rx_derr_set), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(req, d, exp);
  endtask

  // k: 0 error, 1 tx eob, 2 rx eob, 3 tx descriptor error, 4 rx descriptor error
  task automatic drive_src(input int k, input logic [31:0] v);
    case (k)
      0: err_set = v;
      1: tx_eob_set = v;
      2: rx_eob_set = v;
      3: tx_derr_set = v;
      default: rx_derr_set = v;
    endcase
  endtask

  task automatic pulse_src(input int k, input logic [31:0] v);
    @(negedge clk);
    drive_src(k, v);
    @(negedge clk);
    drive_src(k, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_chk("R1 config reset value", 10'h180, 32'h0007_C000);
    rd_chk("R1 error status reset", 10'h181, 32'h0);
    rd_chk("R1 irq enable reset", 10'h182, 32'h0);
    rd_chk("R1 tx activate reset", 10'h184, 32'h0);
    rd_chk("R1 tx pointer reset", 10'h1A0, 32'h0);
    rd_chk("R1 buffer size reset", 10'h1E3, 32'h0);
    chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] d; logic v;
    @(negedge clk);
    chk("R9 rvalid idle", {31'b0, bus_rvalid}, 32'h0);
    rd(10'h180, d, v);
    chk("R9 rvalid one cycle after strobe", {31'b0, v}, 32'h1);
    @(negedge clk);
    chk("R9 rvalid drops", {31'b0, bus_rvalid}, 32'h0);
  endtask

  task automatic t_masks();
    wr(10'h182, 32'hFFFF_FFFF);
    rd_chk("R6 irq enable keeps [4:0]", 10'h182, 32'h0000_001F);
    wr(10'h184, 32'hFFFF_FFFF);
    rd_chk("R6 tx activate set keeps [31:28]", 10'h184, 32'hF000_0000);
    wr(10'h185, 32'h5FFF_FFFF);
    rd_chk("R6 tx activate reset keeps [31:28]", 10'h185, 32'h5000_0000);
    wr(10'h190, 32'hFFFF_FFFF);
    rd_chk("R6 rx activate set keeps [31:30]", 10'h190, 32'hC000_0000);
    wr(10'h191, 32'h7FFF_FFFF);
    rd_chk("R6 rx activate reset keeps [31:30]", 10'h191, 32'h4000_0000);
    wr(10'h180, 32'h7FFF_FFFF);
    rd_chk("R2 config write mask", 10'h180, 32'h00FF_C087);
    wr(10'h182, 32'h0);
  endtask

  task automatic t_windows();
    for (int i = 0; i < TXC; i++) wr(10'(32'h1A0 + i), 32'hA000_0000 + i);
    for (int i = 0; i < RXC; i++) wr(10'(32'h1C0 + i), 32'hC000_1000 + i);
    for (int i = 0; i < RXC; i++) wr(10'(32'h1E0 + i), 32'h0000_1F05 + 32'(i * 16));
    for (int i = 0; i < TXC; i++) rd_chk("R7 tx pointer", 10'(32'h1A0 + i), 32'hA000_0000 + i);
    for (int i = 0; i < RXC; i++) rd_chk("R7 rx pointer", 10'(32'h1C0 + i), 32'hC000_1000 + i);
    for (int i = 0; i < RXC; i++) rd_chk("R7 buffer size low byte", 10'(32'h1E0 + i), 32'h05 + 32'(i * 16));
    wr(10'(32'h1A0 + TXC), 32'hFFFF_FFFF);
    wr(10'(32'h1E0 + RXC), 32'hFFFF_FFFF);
    rd_chk("R8 past tx window reads 0", 10'(32'h1A0 + TXC), 32'h0);
    rd_chk("R8 past size window reads 0", 10'(32'h1E0 + RXC), 32'h0);
    rd_chk("R8 last tx pointer untouched", 10'(32'h1A0 + TXC - 1), 32'hA000_0000 + TXC - 1);
    rd_chk("R8 first tx pointer untouched", 10'h1A0, 32'hA000_0000);
    wr(10'h183, 32'hFFFF_FFFF);
    rd_chk("R8 gap register reads 0", 10'h183, 32'h0);
    rd_chk("R8 top register number reads 0", 10'h3FF, 32'h0);
  endtask

  task automatic w1c_one(input int k, input logic [9:0] a);
    pulse_src(k, 32'h8000_0081);
    rd_chk("R5 set pulse lands", a, 32'h8000_0081);
    wr(a, 32'h0000_0001);
    rd_chk("R4 write-one clears only that bit", a, 32'h8000_0080);
    wr(a, 32'hFFFF_FFFF);
    rd_chk("R4 clear all", a, 32'h0);
  endtask

  task automatic t_status();
    w1c_one(0, 10'h181);
    w1c_one(1, 10'h186);
    w1c_one(2, 10'h192);
    w1c_one(3, 10'h187);
    w1c_one(4, 10'h193);
    pulse_src(1, 32'h3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'h186; bus_wdata = 32'h3; tx_eob_set = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0; tx_eob_set = 32'h0;
    rd_chk("R5 set wins over same-cycle clear", 10'h186, 32'h1);
    wr(10'h186, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    pulse_src(4, 32'h10);
    @(negedge clk);
    chk("R10 irq masked with enable 0", {31'b0, irq}, 32'h0);
    wr(10'h182, 32'h0000_000F);
    @(negedge clk);
    chk("R10 other enables do not pass rx descriptor error", {31'b0, irq}, 32'h0);
    wr(10'h182, 32'h0000_0010);
    @(negedge clk);
    chk("R10 enable bit 4 raises irq", {31'b0, irq}, 32'h1);
    wr(10'h193, 32'h10);
    @(negedge clk);
    chk("R10 irq falls after clear", {31'b0, irq}, 32'h0);
    wr(10'h182, 32'h0000_0002);
    pulse_src(1, 32'h1);
    @(negedge clk);
    chk("R10 enable bit 1 with tx end-of-buffer", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_soft_restart();
    wr(10'h184, 32'hF000_0000);
    pulse_src(0, 32'h55);
    wr(10'h182, 32'h1F);
    wr(10'h180, 32'h8000_0001);
    @(negedge clk);
    chk("R2 irq drops after soft restart", {31'b0, irq}, 32'h0);
    rd_chk("R2 config after soft restart write", 10'h180, 32'h0000_0001);
    rd_chk("R2 enable cleared by soft restart", 10'h182, 32'h0);
    rd_chk("R2 error status cleared by soft restart", 10'h181, 32'h0);
    rd_chk("R2 tx end-of-buffer cleared by soft restart", 10'h186, 32'h0);
    rd_chk("R2 tx activate cleared by soft restart", 10'h184, 32'h0);
    rd_chk("R3 tx pointer kept", 10'h1A2, 32'hA000_0002);
    rd_chk("R3 rx pointer kept", 10'h1C1, 32'hC000_1001);
    rd_chk("R3 buffer size kept", 10'h1E3, 32'h35);
  endtask

  task automatic t_global_reset();
    do_reset();
    rd_chk("R1 global reset clears tx pointer", 10'h1A2, 32'h0);
    rd_chk("R1 global reset restores config", 10'h180, 32'h0007_C000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_read_timing();
    t_masks();
    t_windows();
    t_status();
    t_irq();
    t_soft_restart();
    t_global_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule